// File: doc/BRIEF.md
# AXI Read-Path Shutdown Gate

This block sits on the read channels of an AXI4-Lite link, between an upstream master and a downstream slave that may be torn out and reloaded at run time. While the shutdown request is low it forwards every read command and returns the downstream data unchanged, adding only queue latency. While the request is high, newly accepted reads are not sent to the target that is going away. They are either answered on the spot with a fixed response code, or parked until the request drops and then forwarded.

Every accepted command is tagged with the request level sampled on its acceptance edge, and only that tag decides how the read is handled. A single queue of 16 entries holds each read from acceptance until its upstream R beat. Answers go back in acceptance order, whether they come from the target or from the gate itself. A status flag reports that the read path has drained into shutdown, and an interrupt marks each read that arrived while shutdown was requested.

Top module: `rd_shutdown_gate`

## Requirements
- R1: A read accepted while `shut_req` is low is issued on the downstream AR channel with its address unchanged. Its downstream RDATA and RRESP are returned upstream unchanged.
- R2: At most DEPTH (16) reads are held from acceptance until their upstream R handshake. `s_arready` is low while 16 are held, and every accepted read gets exactly one upstream response.
- R3: How a read is handled depends only on `shut_req` at the clock edge where its AR handshake happens. Changing `shut_req` later does not change that read's handling.
- R4: With REJ_RESP equal to 0, 1 or 2, a read accepted while `shut_req` is high is never issued downstream. It is answered upstream with RDATA all zero and RRESP 2'b10, 2'b11 or 2'b00 respectively.
- R5: With REJ_RESP equal to 3, a read accepted while `shut_req` is high keeps `m_arvalid` low while `shut_req` stays high. After `shut_req` falls, the read is issued downstream and its data is returned.
- R6: Upstream R beats come out in the order the commands were accepted, across both forwarded and locally answered reads. No R beat is presented while no read is held.
- R7: `rd_irq` is high in the cycle after an AR handshake that happened while `shut_req` was high, and low in the cycle after any edge without such a handshake.
- R8: `rd_in_shut` is high exactly when `shut_req` is high and no read accepted with `shut_req` low is still waiting for its upstream response.
- R9: With UP_IN_RP set, `s_arready` is low while `rd_in_shut` is high.
- R10: After reset, `s_arready` is 1 and `s_rvalid`, `m_arvalid`, `rd_irq` and `rd_in_shut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| shut_req | input | 1 | Shutdown request level |
| s_arvalid | input | 1 | Upstream read command valid |
| s_arready | output | 1 | Upstream read command ready |
| s_araddr | input | ADDR_W | Upstream read address |
| s_rvalid | output | 1 | Upstream read data valid |
| s_rready | input | 1 | Upstream read data ready |
| s_rdata | output | DATA_W | Upstream read data |
| s_rresp | output | 2 | Upstream read response code |
| m_arvalid | output | 1 | Downstream read command valid |
| m_arready | input | 1 | Downstream read command ready |
| m_araddr | output | ADDR_W | Downstream read address |
| m_rvalid | input | 1 | Downstream read data valid |
| m_rready | output | 1 | Downstream read data ready |
| m_rdata | input | DATA_W | Downstream read data |
| m_rresp | input | 2 | Downstream read response code |
| rd_in_shut | output | 1 | Read path has drained into shutdown |
| rd_irq | output | 1 | Read accepted while shutdown was requested |

## Verification
A stale or wrong tag shows up in the first R beat of that read: the data or response code is wrong, or a command appears on the downstream AR channel when it should not. A slip in the issue or retire pointer either reorders beats, which the next comparison against the acceptance-order queue catches, or loses or repeats a beat, which shows up when the queue fails to drain. A wrong count of outstanding forwarded reads shows up on `rd_in_shut` at the first check while a forwarded read is still pending.

// File: rtl/rdg_pkg.sv
package rdg_pkg;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;
   localparam logic [1:0] RESP_DECERR = 2'b11;

   // selector value that parks rejected reads instead of answering them
   localparam int unsigned SEL_HOLD = 3;

   function automatic logic [1:0] reject_code(int unsigned sel);
      case (sel)
         0:       return RESP_SLVERR;
         1:       return RESP_DECERR;
         default: return RESP_OKAY;
      endcase
   endfunction

endpackage

// File: rtl/rdg_cmd_queue.sv
// Circular command store with three pointers: write (accept),
// issue (sent downstream or marked local) and retire (R beat done).
module rdg_cmd_queue #(
   parameter int ADDR_W = 32,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [ADDR_W-1:0] push_addr,
   input  logic              push_tag,
   input  logic              iss_adv,
   input  logic              ret_adv,
   output logic              full,
   output logic              iss_valid,
   output logic [ADDR_W-1:0] iss_addr,
   output logic              iss_tag,
   output logic              ret_valid,
   output logic              ret_tag
);
   localparam int IW = $clog2(DEPTH);
   localparam int PW = IW + 1;

   logic [PW-1:0]     wr_p, is_p, rt_p;
   logic [ADDR_W-1:0] addr_mem [DEPTH];
   logic [DEPTH-1:0]  tag_mem;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_p <= '0;
         is_p <= '0;
         rt_p <= '0;
      end else begin
         if (push)    wr_p <= wr_p + PW'(1);
         if (iss_adv) is_p <= is_p + PW'(1);
         if (ret_adv) rt_p <= rt_p + PW'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         addr_mem[wr_p[IW-1:0]] <= push_addr;
         tag_mem[wr_p[IW-1:0]]  <= push_tag;
      end
   end

   assign full      = (wr_p[IW] != rt_p[IW]) && (wr_p[IW-1:0] == rt_p[IW-1:0]);
   assign iss_valid = (wr_p != is_p);
   assign ret_valid = (is_p != rt_p);
   assign iss_addr  = addr_mem[is_p[IW-1:0]];
   assign iss_tag   = tag_mem[is_p[IW-1:0]];
   assign ret_tag   = tag_mem[rt_p[IW-1:0]];

endmodule

// File: rtl/rdg_issue.sv
// Moves the oldest unissued command either onto the downstream AR
// channel or, for a locally answered read, straight to issued.
module rdg_issue
   import rdg_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int REJ_RESP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shut_req,
   input  logic              iss_valid,
   input  logic [ADDR_W-1:0] iss_addr,
   input  logic              iss_tag,
   input  logic              m_arready,
   output logic              m_arvalid,
   output logic [ADDR_W-1:0] m_araddr,
   output logic              iss_adv
);
   localparam bit PARK = (REJ_RESP == int'(SEL_HOLD));

   logic ar_held;   // valid already raised: must stay up until taken
   logic park_now;
   logic local_ans;

   assign local_ans = iss_tag && !PARK;
   assign park_now  = PARK && iss_tag && shut_req && !ar_held;
   assign m_arvalid = iss_valid && !local_ans && !park_now;
   assign m_araddr  = iss_addr;
   assign iss_adv   = (m_arvalid && m_arready) || (iss_valid && local_ans);

   always_ff @(posedge clk) begin
      if (!rst_n) ar_held <= 1'b0;
      else        ar_held <= m_arvalid && !m_arready;
   end

endmodule

// File: rtl/rdg_resp_path.sv
// Upstream R channel: serves the oldest issued read, either from the
// downstream R channel or with a locally built answer.
module rdg_resp_path
   import rdg_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int REJ_RESP = 0
) (
   input  logic              ret_valid,
   input  logic              ret_tag,
   input  logic              s_rready,
   input  logic              m_rvalid,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic [1:0]        m_rresp,
   output logic              s_rvalid,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              m_rready,
   output logic              ret_adv
);
   localparam bit         PARK     = (REJ_RESP == int'(SEL_HOLD));
   localparam logic [1:0] LOC_RESP = reject_code(REJ_RESP);

   logic head_local;

   assign head_local = ret_valid && ret_tag && !PARK;
   assign s_rvalid   = head_local || (ret_valid && m_rvalid);
   assign s_rdata    = head_local ? '0 : m_rdata;
   assign s_rresp    = head_local ? LOC_RESP : m_rresp;
   assign m_rready   = ret_valid && !head_local && s_rready;
   assign ret_adv    = s_rvalid && s_rready;

endmodule

// File: rtl/rd_shutdown_gate.sv
module rd_shutdown_gate
   import rdg_pkg::*;
#(
   parameter int ADDR_W   = 32,
   parameter int DATA_W   = 32,
   parameter int DEPTH    = 16,
   parameter int REJ_RESP = 0,
   parameter int UP_IN_RP = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shut_req,
   input  logic              s_arvalid,
   output logic              s_arready,
   input  logic [ADDR_W-1:0] s_araddr,
   output logic              s_rvalid,
   input  logic              s_rready,
   output logic [DATA_W-1:0] s_rdata,
   output logic [1:0]        s_rresp,
   output logic              m_arvalid,
   input  logic              m_arready,
   output logic [ADDR_W-1:0] m_araddr,
   input  logic              m_rvalid,
   output logic              m_rready,
   input  logic [DATA_W-1:0] m_rdata,
   input  logic [1:0]        m_rresp,
   output logic              rd_in_shut,
   output logic              rd_irq
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("rd_shutdown_gate: DEPTH must be a power of two >= 2");
      end
      if (REJ_RESP < 0 || REJ_RESP > 3) begin : g_bad_sel
         $error("rd_shutdown_gate: REJ_RESP must be 0..3");
      end
   endgenerate

   logic              q_full, iss_valid, iss_tag, iss_adv;
   logic              ret_valid, ret_tag, ret_adv;
   logic [ADDR_W-1:0] iss_addr;
   logic              accept;
   logic [CW-1:0]     pass_cnt;

   assign accept = s_arvalid && s_arready;

   rdg_cmd_queue #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_queue (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (accept),
      .push_addr (s_araddr),
      .push_tag  (shut_req),
      .iss_adv   (iss_adv),
      .ret_adv   (ret_adv),
      .full      (q_full),
      .iss_valid (iss_valid),
      .iss_addr  (iss_addr),
      .iss_tag   (iss_tag),
      .ret_valid (ret_valid),
      .ret_tag   (ret_tag)
   );

   rdg_issue #(.ADDR_W(ADDR_W), .REJ_RESP(REJ_RESP)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .shut_req  (shut_req),
      .iss_valid (iss_valid),
      .iss_addr  (iss_addr),
      .iss_tag   (iss_tag),
      .m_arready (m_arready),
      .m_arvalid (m_arvalid),
      .m_araddr  (m_araddr),
      .iss_adv   (iss_adv)
   );

   rdg_resp_path #(.DATA_W(DATA_W), .REJ_RESP(REJ_RESP)) u_resp (
      .ret_valid (ret_valid),
      .ret_tag   (ret_tag),
      .s_rready  (s_rready),
      .m_rvalid  (m_rvalid),
      .m_rdata   (m_rdata),
      .m_rresp   (m_rresp),
      .s_rvalid  (s_rvalid),
      .s_rdata   (s_rdata),
      .s_rresp   (s_rresp),
      .m_rready  (m_rready),
      .ret_adv   (ret_adv)
   );

   // reads accepted in pass mode that have not yet been answered upstream
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pass_cnt <= '0;
      end else begin
         case ({accept && !shut_req, ret_adv && !ret_tag})
            2'b10:   pass_cnt <= pass_cnt + CW'(1);
            2'b01:   pass_cnt <= pass_cnt - CW'(1);
            default: pass_cnt <= pass_cnt;
         endcase
      end
   end

   assign rd_in_shut = shut_req && (pass_cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) rd_irq <= 1'b0;
      else        rd_irq <= accept && shut_req;
   end

   // an upstream master inside the swapped region is fenced off once drained
   generate
      if (UP_IN_RP != 0) begin : g_fenced
         assign s_arready = !q_full && !rd_in_shut;
      end else begin : g_open
         assign s_arready = !q_full;
      end
   endgenerate

endmodule

// File: rtl/rd_shutdown_gate_chk.sv
module rd_shutdown_gate_chk #(
   parameter int ADDR_W   = 32,
   parameter int DEPTH    = 16,
   parameter int UP_IN_RP = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              shut_req,
   input logic              s_arvalid,
   input logic              s_arready,
   input logic              s_rvalid,
   input logic              s_rready,
   input logic              m_arvalid,
   input logic              m_arready,
   input logic [ADDR_W-1:0] m_araddr,
   input logic              rd_in_shut,
   input logic              rd_irq
);
   localparam int CW = $clog2(DEPTH + 1) + 1;

   logic [CW-1:0] held;
   logic          acc, ret;

   assign acc = s_arvalid && s_arready;
   assign ret = s_rvalid && s_rready;

   always_ff @(posedge clk) begin
      if (!rst_n) held <= '0;
      else        held <= held + CW'(acc) - CW'(ret);
   end

   a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (held == CW'(DEPTH)) |-> !s_arready);

   a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      held <= CW'(DEPTH));

   a_r6_no_spurious_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (held == '0) |-> !s_rvalid);

   a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && shut_req) |=> rd_irq);

   a_r7_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !(acc && shut_req) |=> !rd_irq);

   a_r9_fenced_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ((UP_IN_RP != 0) && rd_in_shut) |-> !s_arready);

   a_r1_ar_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (m_arvalid && !m_arready) |=> (m_arvalid && $stable(m_araddr)));

endmodule

bind rd_shutdown_gate rd_shutdown_gate_chk #(
   .ADDR_W   (ADDR_W),
   .DEPTH    (DEPTH),
   .UP_IN_RP (UP_IN_RP)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .shut_req   (shut_req),
   .s_arvalid  (s_arvalid),
   .s_arready  (s_arready),
   .s_rvalid   (s_rvalid),
   .s_rready   (s_rready),
   .m_arvalid  (m_arvalid),
   .m_arready  (m_arready),
   .m_araddr   (m_araddr),
   .rd_in_shut (rd_in_shut),
   .rd_irq     (rd_irq)
);

// File: tb/sim_rd_shutdown_gate.sv
`timescale 1ns/1ps
module sim_rd_shutdown_gate;

   localparam logic [31:0] KEY = 32'h5A00_00C3;

   typedef struct {
      logic [31:0] d;
      logic [1:0]  r;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   int n_chk = 0;
   int n_err = 0;

   // main instance: REJ_RESP 0 (SLVERR), open upstream
   logic        shut = 0, arvalid = 0, arready, rvalid, rready = 0;
   logic [31:0] araddr = '0, rdata, maraddr, mrdata = '0;
   logic [1:0]  rresp, mrresp = 2'b00;
   logic        marvalid, marready = 0, mrvalid = 0, mrready, inshut, irq;

   rd_shutdown_gate #(.REJ_RESP(0), .UP_IN_RP(0)) u0 (
      .clk(clk), .rst_n(rst_n), .shut_req(shut),
      .s_arvalid(arvalid), .s_arready(arready), .s_araddr(araddr),
      .s_rvalid(rvalid), .s_rready(rready), .s_rdata(rdata), .s_rresp(rresp),
      .m_arvalid(marvalid), .m_arready(marready), .m_araddr(maraddr),
      .m_rvalid(mrvalid), .m_rready(mrready), .m_rdata(mrdata), .m_rresp(mrresp),
      .rd_in_shut(inshut), .rd_irq(irq)
   );

   // side instances: 1 parks (sel 3), 2 answers OKAY fenced, 3 answers DECERR
   logic [3:1]  x_shut = '0, x_arvalid = '0, x_arready, x_rvalid, x_rready = '1;
   logic [3:1]  x_marvalid, x_marready = '1, x_mrvalid = '0, x_mrready, x_inshut, x_irq;
   logic [31:0] x_araddr [1:3];
   logic [31:0] x_rdata [1:3];
   logic [31:0] x_maraddr [1:3];
   logic [31:0] x_mrdata [1:3];
   logic [1:0]  x_rresp [1:3];
   logic [1:0]  x_mrresp [1:3];

   for (genvar i = 1; i <= 3; i++) begin : g_x
      rd_shutdown_gate #(
         .REJ_RESP (i == 1 ? 3 : (i == 2 ? 2 : 1)),
         .UP_IN_RP (i == 2 ? 1 : 0)
      ) ux (
         .clk(clk), .rst_n(rst_n), .shut_req(x_shut[i]),
         .s_arvalid(x_arvalid[i]), .s_arready(x_arready[i]), .s_araddr(x_araddr[i]),
         .s_rvalid(x_rvalid[i]), .s_rready(x_rready[i]), .s_rdata(x_rdata[i]),
         .s_rresp(x_rresp[i]),
         .m_arvalid(x_marvalid[i]), .m_arready(x_marready[i]), .m_araddr(x_maraddr[i]),
         .m_rvalid(x_mrvalid[i]), .m_rready(x_mrready[i]), .m_rdata(x_mrdata[i]),
         .m_rresp(x_mrresp[i]),
         .rd_in_shut(x_inshut[i]), .rd_irq(x_irq[i])
      );
   end

   int ar_cnt1 = 0;
   int ar_cnt3 = 0;
   always @(posedge clk) if (x_marvalid[1] && x_marready[1]) ar_cnt1 <= ar_cnt1 + 1;
   always @(posedge clk) if (x_marvalid[3] && x_marready[3]) ar_cnt3 <= ar_cnt3 + 1;

   exp_t expq[$];
   logic [31:0] dsq[$];
   bit ds_ar_en = 0;
   bit mon_en = 0;
   int ds_ar_cnt = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] expv, input string what);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   // downstream target model for u0
   initial begin
      int c = 0;
      bit popd = 0;
      forever begin
         @(negedge clk);
         if (popd) dsq.delete(0);
         if (!(mrvalid && !popd)) begin
            mrvalid = (dsq.size() > 0);
            mrdata  = (dsq.size() > 0) ? (dsq[0] ^ KEY) : '0;
         end
         popd = 0;
         marready = ds_ar_en && (c % 3 != 2);
         c++;
         #3;
         if (marvalid && marready) begin
            dsq.push_back(maraddr);
            ds_ar_cnt++;
         end
         if (mrvalid && mrready) popd = 1;
      end
   end

   // scoreboard monitor on the upstream R channel of u0
   initial begin
      int m = 0;
      exp_t e;
      forever begin
         @(negedge clk);
         rready = mon_en && (m % 4 != 3);
         m++;
         #2;
         if (rvalid && rready) begin
            if (expq.size() == 0) begin
               chk(1'b0, "R6", rdata, 32'h0, "beat with no read pending");
            end else begin
               e = expq.pop_front();
               chk(rdata == e.d, (e.r != 2'b00) ? "R4" : "R1 R6", rdata, e.d, "rdata");
               chk(rresp == e.r, (e.r != 2'b00) ? "R4" : "R1 R6", 32'(rresp), 32'(e.r), "rresp");
            end
         end
      end
   end

   task automatic issue_read(input logic [31:0] a);
      exp_t e;
      bit   t;
      @(negedge clk);
      arvalid = 1;
      araddr  = a;
      #3;
      while (!arready) begin
         @(negedge clk);
         #3;
      end
      t = shut;
      e.d = t ? 32'h0 : (a ^ KEY);
      e.r = t ? 2'b10 : 2'b00;
      expq.push_back(e);
      @(negedge clk);
      arvalid = 0;
      #3;
      chk(irq == t, "R7", 32'(irq), 32'(t), "rd_irq after accept");
   endtask

   task automatic drain();
      int n = 0;
      while (expq.size() != 0 && n < 3000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
      #3;
      chk(expq.size() == 0, "R2", 32'(expq.size()), 32'h0, "reads left unanswered");
   endtask

   task automatic x_send(input int i, input logic [31:0] a);
      @(negedge clk);
      x_arvalid[i] = 1;
      x_araddr[i]  = a;
      #3;
      while (!x_arready[i]) begin
         @(negedge clk);
         #3;
      end
      @(negedge clk);
      x_arvalid[i] = 0;
   endtask

   task automatic x_wait_r(input int i);
      int n = 0;
      #3;
      while (!x_rvalid[i] && n < 20) begin
         @(negedge clk);
         #3;
         n++;
      end
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      int c;
      for (int i = 1; i <= 3; i++) begin
         x_araddr[i] = '0;
         x_mrdata[i] = '0;
         x_mrresp[i] = 2'b00;
      end
      repeat (3) @(negedge clk);
      rst_n = 1;
      #3;
      // R10 reset state
      chk(arready == 1'b1, "R10", 32'(arready), 32'h1, "s_arready");
      chk(rvalid == 1'b0, "R10", 32'(rvalid), 32'h0, "s_rvalid");
      chk(marvalid == 1'b0, "R10", 32'(marvalid), 32'h0, "m_arvalid");
      chk(irq == 1'b0 && inshut == 1'b0, "R10", {30'h0, irq, inshut}, 32'h0, "irq/in_shut");

      ds_ar_en = 1;
      mon_en   = 1;

      // R1 plain forwarding
      for (int i = 0; i < 6; i++) issue_read(32'h1000 + 32'(i * 4));
      drain();

      // R4 local SLVERR, never forwarded; R8 drained status
      @(negedge clk) shut = 1;
      c = ds_ar_cnt;
      for (int i = 0; i < 4; i++) issue_read(32'h2000 + 32'(i * 4));
      drain();
      chk(ds_ar_cnt == c, "R4", 32'(ds_ar_cnt), 32'(c), "downstream AR count");
      chk(inshut == 1'b1, "R8", 32'(inshut), 32'h1, "in_shut after drain");
      @(negedge clk) shut = 0;
      #3;
      chk(inshut == 1'b0, "R8", 32'(inshut), 32'h0, "in_shut after request drop");

      // R3 tag taken at acceptance, pass read stuck behind blocked target
      ds_ar_en = 0;
      issue_read(32'h3000);
      @(negedge clk) shut = 1;
      #3;
      chk(inshut == 1'b0, "R8", 32'(inshut), 32'h0, "in_shut with pass read pending");
      issue_read(32'h3004);
      @(negedge clk) ds_ar_en = 1;
      drain();
      chk(inshut == 1'b1, "R8", 32'(inshut), 32'h1, "in_shut once drained");
      mon_en = 0;
      issue_read(32'h3008);
      @(negedge clk) shut = 0;
      mon_en = 1;
      drain();

      // R2 fill to 16, 17th must wait
      ds_ar_en = 0;
      mon_en   = 0;
      for (int i = 0; i < 16; i++) issue_read(32'h4000 + 32'(i * 4));
      @(negedge clk);
      #3;
      chk(arready == 1'b0, "R2", 32'(arready), 32'h0, "s_arready with 16 held");
      fork
         issue_read(32'h4100);
         begin
            repeat (4) @(negedge clk);
            ds_ar_en = 1;
            mon_en   = 1;
         end
      join
      drain();

      // R6 mixed order
      for (int i = 0; i < 12; i++) begin
         @(negedge clk) shut = (i % 3 == 1);
         issue_read(32'h5000 + 32'(i * 4));
      end
      @(negedge clk) shut = 0;
      drain();

      // R5 parking variant
      @(negedge clk) x_shut[1] = 1;
      c = ar_cnt1;
      x_send(1, 32'h40);
      repeat (6) @(negedge clk);
      #3;
      chk(ar_cnt1 == c && !x_marvalid[1], "R5", 32'(ar_cnt1), 32'(c), "parked read issued");
      chk(!x_rvalid[1], "R5", 32'(x_rvalid[1]), 32'h0, "parked read answered");
      @(negedge clk) x_shut[1] = 0;
      #3;
      chk(x_marvalid[1] && x_maraddr[1] == 32'h40, "R5", x_maraddr[1], 32'h40, "released address");
      @(negedge clk);
      x_mrvalid[1] = 1;
      x_mrdata[1]  = 32'h0000_1234;
      x_wait_r(1);
      chk(x_rvalid[1] && x_rdata[1] == 32'h1234, "R5", x_rdata[1], 32'h1234, "released data");
      @(negedge clk) x_mrvalid[1] = 0;

      // R4 DECERR variant
      @(negedge clk) x_shut[3] = 1;
      c = ar_cnt3;
      x_send(3, 32'h44);
      x_wait_r(3);
      chk(x_rvalid[3] && x_rresp[3] == 2'b11, "R4", 32'(x_rresp[3]), 32'h3, "DECERR code");
      chk(x_rdata[3] == 32'h0, "R4", x_rdata[3], 32'h0, "local data zero");
      repeat (3) @(negedge clk);
      #3;
      chk(ar_cnt3 == c, "R4", 32'(ar_cnt3), 32'(c), "DECERR read forwarded");
      @(negedge clk) x_shut[3] = 0;

      // R6/R8/R9 OKAY fenced variant: local answer waits behind forwarded read
      x_send(2, 32'h80);
      @(negedge clk) x_shut[2] = 1;
      #3;
      chk(!x_inshut[2], "R8", 32'(x_inshut[2]), 32'h0, "in_shut with forwarded read");
      chk(x_arready[2], "R9", 32'(x_arready[2]), 32'h1, "ready before drained");
      x_send(2, 32'h84);
      repeat (3) @(negedge clk);
      #3;
      chk(!x_rvalid[2], "R6", 32'(x_rvalid[2]), 32'h0, "local beat overtook forwarded");
      @(negedge clk);
      x_mrvalid[2] = 1;
      x_mrdata[2]  = 32'h0000_BEEF;
      x_wait_r(2);
      chk(x_rvalid[2] && x_rdata[2] == 32'hBEEF, "R6", x_rdata[2], 32'hBEEF, "first beat");
      @(negedge clk) x_mrvalid[2] = 0;
      x_wait_r(2);
      chk(x_rvalid[2] && x_rresp[2] == 2'b00 && x_rdata[2] == 32'h0, "R4",
          {x_rdata[2][29:0], x_rresp[2]}, 32'h0, "OKAY local beat");
      repeat (2) @(negedge clk);
      #3;
      chk(x_inshut[2], "R8", 32'(x_inshut[2]), 32'h1, "in_shut fenced");
      chk(!x_arready[2], "R9", 32'(x_arready[2]), 32'h0, "ready while fenced");

      finish_run();
   end

endmodule